// File: doc/BRIEF.md
# Register-Mapped Stream FIFO Bridge

This block connects a processor's word-addressed register port to a pair of AXI4-Stream channels. On the transmit side, software writes 32-bit words into a transmit FIFO. Nothing goes out on the stream until software writes a byte count to the launch register. The block then sends the matching number of words as one packet and marks the final word with TLAST.

On the receive side, incoming stream beats are stored in a receive FIFO. When a beat carrying TLAST arrives, the packet's byte length is pushed onto a small length queue. Software first reads the occupancy register to see whether data is waiting. It then reads the length register, which pops that packet's byte count, and finally drains the words through the receive data register.

A four-bit interrupt status register reports four events: a packet has finished sending, a packet has arrived, and each FIFO has been cleared. Software clears these bits by writing ones to them. They are combined with an enable mask to drive a single interrupt line. Each FIFO can be cleared on its own by writing a key value, and a third key register clears both FIFOs at once.

Top module: `stream_fifo_bridge`

## Requirements
- R1: After reset, transmit vacancy (index 3) reads TX_DEPTH, receive occupancy (index 7) reads 0, status (index 0) reads 0, irq is 0, m_tvalid is 0 and s_tready is 1.
- R2: Each write to index 4 pushes the written word into the transmit FIFO, and vacancy drops by one. A write made while the FIFO is full is discarded.
- R3: Writing byte count N (bits 15:0) to index 5 launches ceil(N/4) words in FIFO order, with m_tlast set only on the final word. A count of zero, or a launch written while a packet is still in flight, is ignored.
- R4: m_tvalid is high only while the launched packet has words left and the FIFO holds data. While m_tready is low, m_tvalid, m_tdata and m_tlast hold their values.
- R5: Vacancy rises by one for every transmitted beat, so it returns to TX_DEPTH once a packet has fully drained.
- R6: Every accepted receive beat is stored. Index 7 reports the number of stored words, and each read of index 8 returns the oldest word and removes it.
- R7: A receive beat carrying s_tlast queues the packet length (beats × 4). Each read of index 9 returns and removes the oldest queued length, and returns 0 when the queue is empty.
- R8: s_tready is low whenever the receive FIFO is full or the length queue is full.
- R9: Status bits are: bit 0 transmit packet done, bit 1 receive packet queued, bit 2 transmit clear done, bit 3 receive clear done. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. Index 1 is a read/write enable mask, and irq = OR(status AND mask).
- R10: Writing 0x000000A5 to index 2 empties the transmit FIFO, aborts any launch and sets status bit 2. The same key written to index 6 empties the receive FIFO and the length queue and sets bit 3. Written to index 10, it does both. A write of any other value to these three indices has no effect.
- R11: Reading status, vacancy or occupancy changes nothing, so repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects occur at the clock edge) |
| reg_addr | input | 4 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational while reg_rd is high, otherwise 0 |
| irq | output | 1 | Interrupt, OR of the enabled status bits |
| m_tvalid | output | 1 | Transmit stream valid |
| m_tready | input | 1 | Transmit stream ready |
| m_tdata | output | 32 | Transmit stream data |
| m_tlast | output | 1 | Transmit end of packet |
| s_tvalid | input | 1 | Receive stream valid |
| s_tready | output | 1 | Receive stream ready |
| s_tdata | input | 32 | Receive stream data |
| s_tlast | input | 1 | Receive end of packet |

## Verification
Sweeps over every transmit packet size, two byte-count roundings and two back-pressure patterns tie each emitted beat to the word that was pushed. A stale remaining-word counter shows up as an extra or missing beat, or as TLAST on the wrong word, within one packet. Every receive packet size up to the FIFO depth is sent and read back, so an off-by-one in the beat counter corrupts the very next length read. Full-FIFO and full-queue back-pressure, key clears and status write-one-to-clear are each observed at the ports in the cycle after they happen.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    localparam int LEN_W = 16;
    localparam logic [31:0] CLEAR_KEY = 32'h0000_00A5;

    typedef enum logic [3:0] {
        RA_STATUS = 4'd0,
        RA_ENABLE = 4'd1,
        RA_TXCLR  = 4'd2,
        RA_TXVAC  = 4'd3,
        RA_TXDATA = 4'd4,
        RA_TXLEN  = 4'd5,
        RA_RXCLR  = 4'd6,
        RA_RXOCC  = 4'd7,
        RA_RXDATA = 4'd8,
        RA_RXLEN  = 4'd9,
        RA_BOTHCLR = 4'd10
    } reg_idx_e;

    typedef struct packed {
        logic rx_clr_done;
        logic tx_clr_done;
        logic rx_pkt;
        logic tx_done;
    } status_t;

    function automatic logic [LEN_W-1:0] bytes_to_words(input logic [LEN_W-1:0] nbytes);
        logic [LEN_W:0] t;
        t = {1'b0, nbytes} + (LEN_W+1)'(3);
        return {1'b0, t[LEN_W:2]};
    endfunction

endpackage

// File: rtl/sfb_fifo.sv
module sfb_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2 / R6: occupancy never exceeds the storage depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R2: a push into a full FIFO leaves occupancy unchanged
    a_r2_drop_when_full: assert property (@(posedge clk) disable iff (rst || clr)
        full && push && !pop |=> full);

endmodule

// File: rtl/sfb_tx_engine.sv
module sfb_tx_engine
    import sfb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             launch,
    input  logic [LEN_W-1:0] launch_words,
    input  logic             fifo_empty,
    input  logic [31:0]      fifo_head,
    input  logic             m_tready,
    output logic             m_tvalid,
    output logic [31:0]      m_tdata,
    output logic             m_tlast,
    output logic             beat_pop,
    output logic             pkt_done
);
    logic [LEN_W-1:0] remaining;
    logic             idle;

    assign idle     = (remaining == '0);
    assign m_tvalid = !idle && !fifo_empty;
    assign m_tdata  = fifo_head;
    assign m_tlast  = (remaining == LEN_W'(1));
    assign beat_pop = m_tvalid && m_tready;
    assign pkt_done = beat_pop && m_tlast;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            remaining <= '0;
        end else if (idle) begin
            if (launch && launch_words != '0) remaining <= launch_words;
        end else if (beat_pop) begin
            remaining <= remaining - 1'b1;
        end
    end

    // R4: a stalled beat keeps its payload
    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (rst || clr)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

    // R3: the TLAST beat ends the packet
    a_r3_last_ends_packet: assert property (@(posedge clk) disable iff (rst || clr)
        m_tvalid && m_tready && m_tlast |=> !m_tvalid);

endmodule

// File: rtl/sfb_rx_tracker.sv
module sfb_rx_tracker
    import sfb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             s_tvalid,
    input  logic             s_tlast,
    input  logic             data_full,
    input  logic             len_full,
    output logic             s_tready,
    output logic             data_push,
    output logic             len_push,
    output logic [LEN_W-1:0] len_value
);
    logic [LEN_W-3:0] beats;

    assign s_tready  = !data_full && !len_full;
    assign data_push = s_tvalid && s_tready;
    assign len_push  = data_push && s_tlast;
    assign len_value = {beats + 1'b1, 2'b00};

    always_ff @(posedge clk) begin
        if (rst || clr)     beats <= '0;
        else if (len_push)  beats <= '0;
        else if (data_push) beats <= beats + 1'b1;
    end

    // R7: a queued length is a nonzero whole number of words
    a_r7_len_word_multiple: assert property (@(posedge clk) disable iff (rst)
        len_push |-> (len_value[1:0] == 2'b00) && (len_value != '0));

    // R7: the beat after a closing beat starts a fresh count
    a_r7_count_restarts: assert property (@(posedge clk) disable iff (rst || clr)
        len_push |=> len_value == LEN_W'(4));

endmodule

// File: rtl/stream_fifo_bridge.sv
module stream_fifo_bridge
    import sfb_pkg::*;
#(
    parameter int TX_DEPTH  = 8,
    parameter int RX_DEPTH  = 8,
    parameter int LEN_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        m_tvalid,
    input  logic        m_tready,
    output logic [31:0] m_tdata,
    output logic        m_tlast,
    input  logic        s_tvalid,
    output logic        s_tready,
    input  logic [31:0] s_tdata,
    input  logic        s_tlast
);
    localparam int TXCW = $clog2(TX_DEPTH + 1);
    localparam int RXCW = $clog2(RX_DEPTH + 1);
    localparam int LQCW = $clog2(LEN_DEPTH + 1);

    reg_idx_e idx;
    assign idx = reg_idx_e'(reg_addr);

    logic wr_hit_key, tx_clr, rx_clr;
    assign wr_hit_key = reg_wr && (reg_wdata == CLEAR_KEY);
    assign tx_clr = wr_hit_key && (idx == RA_TXCLR || idx == RA_BOTHCLR);
    assign rx_clr = wr_hit_key && (idx == RA_RXCLR || idx == RA_BOTHCLR);

    // transmit path
    logic [31:0]     tx_head;
    logic            tx_full, tx_empty, tx_pop, tx_done;
    logic [TXCW-1:0] tx_count;

    sfb_fifo #(.W(32), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .clr(tx_clr),
        .push(reg_wr && idx == RA_TXDATA), .din(reg_wdata),
        .pop(tx_pop), .dout(tx_head),
        .full(tx_full), .empty(tx_empty), .count(tx_count)
    );

    sfb_tx_engine u_tx_engine (
        .clk(clk), .rst(rst), .clr(tx_clr),
        .launch(reg_wr && idx == RA_TXLEN),
        .launch_words(bytes_to_words(reg_wdata[LEN_W-1:0])),
        .fifo_empty(tx_empty), .fifo_head(tx_head),
        .m_tready(m_tready), .m_tvalid(m_tvalid),
        .m_tdata(m_tdata), .m_tlast(m_tlast),
        .beat_pop(tx_pop), .pkt_done(tx_done)
    );

    // receive path
    logic [31:0]      rx_head;
    logic             rx_full, rx_empty, rx_push;
    logic [RXCW-1:0]  rx_count;
    logic [LEN_W-1:0] lq_head, lq_in;
    logic             lq_full, lq_empty, lq_push;
    logic [LQCW-1:0]  lq_count;

    sfb_fifo #(.W(32), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .clr(rx_clr),
        .push(rx_push), .din(s_tdata),
        .pop(reg_rd && idx == RA_RXDATA), .dout(rx_head),
        .full(rx_full), .empty(rx_empty), .count(rx_count)
    );

    sfb_fifo #(.W(LEN_W), .DEPTH(LEN_DEPTH)) u_len_queue (
        .clk(clk), .rst(rst), .clr(rx_clr),
        .push(lq_push), .din(lq_in),
        .pop(reg_rd && idx == RA_RXLEN), .dout(lq_head),
        .full(lq_full), .empty(lq_empty), .count(lq_count)
    );

    sfb_rx_tracker u_rx_tracker (
        .clk(clk), .rst(rst), .clr(rx_clr),
        .s_tvalid(s_tvalid), .s_tlast(s_tlast),
        .data_full(rx_full), .len_full(lq_full),
        .s_tready(s_tready), .data_push(rx_push),
        .len_push(lq_push), .len_value(lq_in)
    );

    // status and enable
    status_t status_q, events, enable_q;
    logic    status_w1c;

    assign events = '{rx_clr_done: rx_clr, tx_clr_done: tx_clr,
                      rx_pkt: lq_push, tx_done: tx_done};
    assign status_w1c = reg_wr && idx == RA_STATUS;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (status_q & ~(status_w1c ? status_t'(reg_wdata[3:0]) : status_t'(4'b0)))
                        | events;
            if (reg_wr && idx == RA_ENABLE) enable_q <= status_t'(reg_wdata[3:0]);
        end
    end

    assign irq = |(status_q & enable_q);

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (idx)
                RA_STATUS: reg_rdata = {28'b0, status_q};
                RA_ENABLE: reg_rdata = {28'b0, enable_q};
                RA_TXVAC:  reg_rdata = 32'(TX_DEPTH) - 32'(tx_count);
                RA_RXOCC:  reg_rdata = 32'(rx_count);
                RA_RXDATA: reg_rdata = rx_empty ? 32'b0 : rx_head;
                RA_RXLEN:  reg_rdata = lq_empty ? 32'b0 : 32'(lq_head);
                default:   reg_rdata = '0;
            endcase
        end
    end

    // R9: written ones clear status bits unless a new event coincides
    a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
        status_w1c && events == '0 |=> (status_q & status_t'($past(reg_wdata[3:0]))) == '0);

    // R10: a transmit clear empties the FIFO, stops the stream, flags it
    a_r10_tx_clear: assert property (@(posedge clk) disable iff (rst)
        tx_clr |=> tx_count == '0 && !m_tvalid && status_q.tx_clr_done);

    // R10: a receive clear empties data and length storage
    a_r10_rx_clear: assert property (@(posedge clk) disable iff (rst)
        rx_clr |=> rx_count == '0 && lq_count == '0 && s_tready);

    // R8: no acceptance while receive storage is full
    a_r8_stall_when_full: assert property (@(posedge clk) disable iff (rst)
        (rx_full || lq_full) |-> !s_tready);

    // R1: quiet outputs in the first cycle after reset
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> !m_tvalid && !irq && s_tready);

endmodule

// File: tb/test_stream_fifo_bridge.sv
module test_stream_fifo_bridge;
    localparam int TXD = 8;
    localparam int RXD = 8;
    localparam int LQD = 4;

    logic        clk = 0;
    logic        rst = 1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        m_tvalid, m_tlast;
    logic        m_tready = 1;
    logic [31:0] m_tdata;
    logic        s_tvalid = 0, s_tlast = 0;
    logic        s_tready;
    logic [31:0] s_tdata = 0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    stream_fifo_bridge #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .LEN_DEPTH(LQD)) i_stream_fifo_bridge (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tdata(m_tdata), .m_tlast(m_tlast), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(v == exp, req, v, exp);
    endtask

    // Drain n beats with data base+k, ready always (mode 0) or every other cycle (mode 1)
    task automatic drain(input int n, input logic [31:0] base, input int mode);
        int idx = 0;
        int cyc = 0;
        while (idx < n && cyc < 200) begin
            m_tready = (mode == 0) ? 1'b1 : cyc[0];
            #1;
            if (m_tready) begin
                if (m_tvalid) begin
                    chk(m_tdata == base + 32'(idx), "R3 data order", m_tdata, base + 32'(idx));
                    chk(m_tlast == (idx == n - 1), "R3 tlast position", 32'(m_tlast), 32'(idx == n - 1));
                    idx++;
                end
            end else begin
                chk(m_tvalid == 1'b1 && m_tdata == base + 32'(idx), "R4 hold while stalled",
                    m_tdata, base + 32'(idx));
            end
            cyc++;
            @(negedge clk);
        end
        chk(idx == n, "R3 beat count", 32'(idx), 32'(n));
        m_tready = 1;
    endtask

    task automatic rx_beat(input logic [31:0] d, input logic last);
        @(negedge clk);
        s_tvalid = 1; s_tdata = d; s_tlast = last;
        #1;
        while (!s_tready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic rx_idle();
        @(negedge clk);
        s_tvalid = 0; s_tlast = 0;
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'(checks), 32'hFFFF_FFFF);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        #1;
        chk(m_tvalid == 0, "R1 tvalid", 32'(m_tvalid), 0);
        chk(s_tready == 1, "R1 tready", 32'(s_tready), 1);
        chk(irq == 0, "R1 irq", 32'(irq), 0);
        rd_chk(3, TXD, "R1 vacancy");
        rd_chk(7, 0, "R1 occupancy");
        rd_chk(0, 0, "R1 status");

        // R2 R3 R4 R5 transmit sweep
        for (int n = 1; n <= TXD; n++) begin
            for (int mode = 0; mode < 2; mode++) begin
                for (int vr = 0; vr < 2; vr++) begin
                    logic [31:0] base;
                    base = 32'(n * 4096 + mode * 256 + vr * 64);
                    for (int k = 0; k < n; k++) wr(4, base + 32'(k));
                    rd_chk(3, 32'(TXD - n), "R2 vacancy after pushes");
                    wr(5, 32'(n * 4 - vr * 3));
                    drain(n, base, mode);
                    #1;
                    chk(m_tvalid == 0, "R4 idle after packet", 32'(m_tvalid), 0);
                    rd_chk(3, TXD, "R5 vacancy restored");
                    rd_chk(0, 32'h1, "R9 tx done bit");
                    wr(0, 32'h1);
                    rd_chk(0, 32'h0, "R9 w1c tx done");
                end
            end
        end

        // R2 overflow dropped
        for (int k = 0; k < TXD + 2; k++) wr(4, 32'h100 + 32'(k));
        rd_chk(3, 0, "R2 vacancy full");
        wr(5, 32'(4 * TXD));
        drain(TXD, 32'h100, 0);
        rd_chk(3, TXD, "R2 overflow words dropped");

        // R3 zero length ignored
        wr(4, 32'h77);
        wr(5, 0);
        repeat (3) @(negedge clk);
        #1 chk(m_tvalid == 0, "R3 zero length ignored", 32'(m_tvalid), 0);
        wr(5, 4);
        drain(1, 32'h77, 0);

        // R3 launch while busy ignored, R10 clears
        m_tready = 0;
        for (int k = 0; k < 3; k++) wr(4, 32'h200 + 32'(k));
        wr(5, 8);
        wr(5, 4);
        drain(2, 32'h200, 1);
        repeat (2) @(negedge clk);
        #1 chk(m_tvalid == 0, "R3 busy launch ignored", 32'(m_tvalid), 0);
        rd_chk(3, TXD - 1, "R3 leftover word");
        wr(2, 32'h5A);
        rd_chk(3, TXD - 1, "R10 wrong key ignored");
        wr(0, 32'hF);
        wr(2, 32'hA5);
        rd_chk(3, TXD, "R10 tx clear vacancy");
        rd_chk(0, 32'h4, "R10 tx clear status");
        wr(0, 32'hF);

        // R6 R7 receive sweep
        for (int kb = 1; kb <= RXD; kb++) begin
            for (int j = 0; j < kb; j++) rx_beat(32'(kb * 1000 + j), j == kb - 1);
            rx_idle();
            rd_chk(7, 32'(kb), "R6 occupancy");
            rd_chk(0, 32'h2, "R9 rx packet bit");
            rd_chk(9, 32'(kb * 4), "R7 packet length");
            rd_chk(9, 0, "R7 empty length queue");
            for (int j = 0; j < kb; j++) rd_chk(8, 32'(kb * 1000 + j), "R6 data order");
            rd_chk(7, 0, "R6 drained");
            wr(0, 32'h2);
        end

        // R8 length queue full, R11 no side effects
        for (int p = 0; p < LQD; p++) rx_beat(32'h300 + 32'(p), 1'b1);
        rx_idle();
        #1 chk(s_tready == 0, "R8 stall on length queue full", 32'(s_tready), 0);
        rd(7, v); rd(7, v2);
        chk(v == v2 && v == LQD, "R11 occupancy read repeatable", v2, LQD);
        rd(0, v); rd(0, v2);
        chk(v == v2 && v == 2, "R11 status read repeatable", v2, 2);
        rd_chk(9, 4, "R7 pop one length");
        #1 chk(s_tready == 1, "R8 ready after pop", 32'(s_tready), 1);
        wr(0, 32'hF);
        wr(6, 32'hA5);
        rd_chk(7, 0, "R10 rx clear occupancy");
        rd_chk(9, 0, "R10 rx clear lengths");
        rd_chk(0, 32'h8, "R10 rx clear status");
        wr(0, 32'hF);

        // R8 data FIFO full, R10 both clear
        for (int j = 0; j < RXD; j++) rx_beat(32'h400 + 32'(j), 1'b0);
        rx_idle();
        #1 chk(s_tready == 0, "R8 stall on data full", 32'(s_tready), 0);
        rd_chk(7, RXD, "R8 occupancy full");
        wr(4, 32'h55);
        wr(10, 32'hA5);
        rd_chk(7, 0, "R10 both clear rx");
        rd_chk(3, TXD, "R10 both clear tx");
        rd_chk(0, 32'hC, "R10 both clear status");
        wr(0, 32'hF);

        // R9 enable mask and irq
        wr(1, 32'h2);
        rd_chk(1, 32'h2, "R9 enable readback");
        rx_beat(32'h9, 1'b1);
        rx_idle();
        #1 chk(irq == 1, "R9 irq on rx packet", 32'(irq), 1);
        wr(0, 32'h0);
        #1 chk(irq == 1, "R9 zero write keeps bit", 32'(irq), 1);
        wr(0, 32'h2);
        #1 chk(irq == 0, "R9 w1c drops irq", 32'(irq), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule